// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core with Fault Halt

This block is a small sequential processor. It has four 16-bit general registers, a 16-bit program counter that counts in words, and a single zero flag. Each instruction takes a fetch, a wait for the read data, and an execute step. A store takes one more step to write memory. The core works through a single-port word memory that sits outside the block. That memory has a valid/ready request channel and a read-response strobe. The core supports load immediate, add, subtract, multiply, unsigned divide, register-indirect store, unconditional jump and halt.

The core stops on a halt instruction, on a divide by zero, or on an opcode it does not know, and it reports why it stopped as a 2-bit code. A fault is atomic: the instruction that faults leaves every register, the flag, memory and the program counter unchanged. Once the core has halted it stays frozen until a synchronous reset.

A cycle counter runs while the core is active, for observation only. The register file is also brought out for observation.

Memory request rules: `mem_req_valid` stays high, with address, write enable and write data held constant, until the cycle in which `mem_req_ready` is high. Only one request is outstanding at a time. After a read is accepted, the core waits for `mem_rsp_valid` and ignores that strobe in any other state. Writes get no response. The memory may hold back a request by keeping `mem_req_ready` low for any number of cycles.

Top module: `mc16_core`

## Requirements
- R1: A synchronous active-high reset clears all four registers, the program counter, the zero flag, the halt reason and the cycle counter. Fetching then starts at address 0.
- R2: A memory request keeps its valid, address, write enable and write data constant until it is accepted. A read's data is taken only from the `mem_rsp_valid` cycle that follows the accepted read.
- R3: Opcode 1 (LOAD, opcode in bits 15:12) writes the zero-extended 8-bit immediate in bits 7:0 into the register indexed by bits 9:8.
- R4: Opcodes 2 (ADD), 4 (SUB), 5 (MUL) and 6 (DIV) combine the register indexed by bits 9:8 with the register indexed by bits 1:0. The result goes back into the register indexed by bits 9:8, truncated to 16 bits. DIV is unsigned.
- R5: The zero flag changes only on ADD, SUB, MUL and DIV, and is set exactly when the 16-bit result is zero.
- R6: Opcode 3 (STORE) writes the register indexed by bits 9:8 to the memory word whose address is the register indexed by bits 1:0. Any 16-bit address can be reached.
- R7: Opcode 7 (JMP) loads the program counter with the zero-extended target in bits 11:0. Every other completed instruction except halt adds one to the program counter.
- R8: Opcode 15 (HALT) stops the core with reason code 1 and leaves the program counter on the halt word. The reason code is 0 while the core runs.
- R9: DIV with a zero divisor stops the core with reason code 2. No register, flag, memory word or program counter changes.
- R10: Opcodes 0 and 8 to 14 are illegal. They stop the core with reason code 3 and change no architectural state.
- R11: Once halted, the core issues no memory requests, ignores response strobes, and keeps its registers, flag, program counter, reason and counter unchanged until reset.
- R12: The cycle counter adds one on every clock while the core is not halted and holds while halted. Results do not depend on how long the memory stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 16 | Read data |
| halted | output | 1 | Core has stopped |
| halt_reason | output | 2 | 0 running, 1 halt, 2 divide by zero, 3 illegal opcode |
| pc | output | 16 | Program counter |
| zero_flag | output | 1 | Zero flag |
| arch_regs | output | 64 | Registers R0..R3, R0 in bits 15:0 |
| cycle_count | output | CNT_W | Active-cycle counter |

## Verification
The assertions check the following on every cycle:
- a pending request is held steady until it is accepted;
- a halt is sticky and quiet on the memory port;
- a halted core always carries a nonzero reason;
- the counter steps while running and freezes when halted;
- the cycle in which the core halts leaves the program counter, registers and flag untouched, which is the atomic-fault rule.

The arithmetic results, the field decoding, the flag values, where a store lands, jump targets and the reason codes can only be shown by running programs. So can the fact that results stay the same when the memory stalls at random. The bench covers these by sweeping every operation over a grid of operand values and every illegal opcode.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int W      = 16;
  localparam int NREG   = 4;
  localparam int RIDX_W = $clog2(NREG);
  localparam int TGT_W  = 12;
  localparam int IMM_W  = 8;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'h1,
    OP_ADD   = 4'h2,
    OP_STORE = 4'h3,
    OP_SUB   = 4'h4,
    OP_MUL   = 4'h5,
    OP_DIV   = 4'h6,
    OP_JMP   = 4'h7,
    OP_HALT  = 4'hF
  } opcode_t;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_HALT    = 2'd1,
    RSN_DIVZERO = 2'd2,
    RSN_ILLEGAL = 2'd3
  } reason_t;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_WAIT,
    ST_EXEC,
    ST_STORE,
    ST_HALT
  } state_t;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int N     = 4,
  parameter int DW    = 16,
  localparam int IW   = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [IW-1:0]   raddr_a,
  input  logic [IW-1:0]   raddr_b,
  output logic [DW-1:0]   rdata_a,
  output logic [DW-1:0]   rdata_b,
  output logic [N*DW-1:0] flat
);
  logic [DW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= '0;
      else if (we && (waddr == IW'(g)))         regs[g] <= wdata;
    end
    assign flat[g*DW +: DW] = regs[g];
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc16_decode.sv
module mc16_decode
  import mc16_pkg::*;
(
  input  logic [W-1:0]      ir,
  output opcode_t           op,
  output logic [RIDX_W-1:0] idx_a,
  output logic [RIDX_W-1:0] idx_b,
  output logic [W-1:0]      imm,
  output logic [W-1:0]      target,
  output logic              is_alu,
  output logic              illegal
);
  assign op     = opcode_t'(ir[15:12]);
  assign idx_a  = ir[8 +: RIDX_W];
  assign idx_b  = ir[0 +: RIDX_W];
  assign imm    = {{(W-IMM_W){1'b0}}, ir[IMM_W-1:0]};
  assign target = {{(W-TGT_W){1'b0}}, ir[TGT_W-1:0]};

  always_comb begin
    is_alu  = 1'b0;
    illegal = 1'b0;
    case (ir[15:12])
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: is_alu = 1'b1;
      OP_LOAD, OP_STORE, OP_JMP, OP_HALT: ;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
(
  input  opcode_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         div_zero
);
  assign div_zero = (op == OP_DIV) && (b == '0);

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = (b == '0) ? '0 : a / b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [15:0]      mem_req_addr,
  output logic [15:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [15:0]      mem_rsp_rdata,
  output logic             halted,
  output logic [1:0]       halt_reason,
  output logic [15:0]      pc,
  output logic             zero_flag,
  output logic [63:0]      arch_regs,
  output logic [CNT_W-1:0] cycle_count
);
  state_t            state;
  logic [W-1:0]      pc_q, ir_q;
  logic              zf_q;
  reason_t           rsn_q;
  logic [CNT_W-1:0]  cnt_q;

  opcode_t           d_op;
  logic [RIDX_W-1:0] d_ia, d_ib;
  logic [W-1:0]      d_imm, d_tgt;
  logic              d_alu, d_ill;
  logic [W-1:0]      rd_a, rd_b, alu_res;
  logic              alu_dz;
  logic              rf_we;
  logic [W-1:0]      rf_wd;

  mc16_decode u_dec (
    .ir(ir_q), .op(d_op), .idx_a(d_ia), .idx_b(d_ib),
    .imm(d_imm), .target(d_tgt), .is_alu(d_alu), .illegal(d_ill)
  );

  mc16_regfile #(.N(NREG), .DW(W)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(d_ia), .wdata(rf_wd),
    .raddr_a(d_ia), .raddr_b(d_ib), .rdata_a(rd_a), .rdata_b(rd_b),
    .flat(arch_regs)
  );

  mc16_alu u_alu (
    .op(d_op), .a(rd_a), .b(rd_b), .res(alu_res), .div_zero(alu_dz)
  );

  // Register writes commit only in execute and never for a faulting divide.
  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_res;
    if (state == ST_EXEC && !d_ill) begin
      if (d_op == OP_LOAD) begin
        rf_we = 1'b1;
        rf_wd = d_imm;
      end else if (d_alu && !alu_dz) begin
        rf_we = 1'b1;
      end
    end
  end

  assign mem_req_valid = (state == ST_FETCH) || (state == ST_STORE);
  assign mem_req_we    = (state == ST_STORE);
  assign mem_req_addr  = (state == ST_STORE) ? rd_b : pc_q;
  assign mem_req_wdata = rd_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc_q  <= '0;
      ir_q  <= '0;
      zf_q  <= 1'b0;
      rsn_q <= RSN_NONE;
      cnt_q <= '0;
    end else begin
      if (state != ST_HALT) cnt_q <= cnt_q + 1'b1;
      case (state)
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          ir_q  <= mem_rsp_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (d_ill) begin
            rsn_q <= RSN_ILLEGAL;
            state <= ST_HALT;
          end else if (d_alu) begin
            if (alu_dz) begin
              rsn_q <= RSN_DIVZERO;
              state <= ST_HALT;
            end else begin
              zf_q  <= (alu_res == '0);
              pc_q  <= pc_q + 1'b1;
              state <= ST_FETCH;
            end
          end else begin
            case (d_op)
              OP_HALT: begin
                rsn_q <= RSN_HALT;
                state <= ST_HALT;
              end
              OP_JMP: begin
                pc_q  <= d_tgt;
                state <= ST_FETCH;
              end
              OP_STORE: state <= ST_STORE;
              default: begin
                pc_q  <= pc_q + 1'b1;
                state <= ST_FETCH;
              end
            endcase
          end
        end
        ST_STORE: if (mem_req_ready) begin
          pc_q  <= pc_q + 1'b1;
          state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign halted      = (state == ST_HALT);
  assign halt_reason = rsn_q;
  assign pc          = pc_q;
  assign zero_flag   = zf_q;
  assign cycle_count = cnt_q;
endmodule

// File: rtl/mc16_core_checker.sv
module mc16_core_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [15:0]      mem_req_addr,
  input logic [15:0]      mem_req_wdata,
  input logic             halted,
  input logic [1:0]       halt_reason,
  input logic [15:0]      pc,
  input logic             zero_flag,
  input logic [63:0]      arch_regs,
  input logic [CNT_W-1:0] cycle_count
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  assert_reason_set_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (halt_reason != 2'd0));

  assert_running_reason_R8: assert property (@(posedge clk) disable iff (rst)
    !halted |-> (halt_reason == 2'd0));

  assert_halt_atomic_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> ($stable(pc) && $stable(arch_regs) && $stable(zero_flag)));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(arch_regs) && $stable(zero_flag) && $stable(halt_reason)));

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req_valid);

  assert_count_step_R12: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (cycle_count == $past(cycle_count) + 1'b1));

  assert_count_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(cycle_count));
endmodule

bind mc16_core mc16_core_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .halted(halted), .halt_reason(halt_reason), .pc(pc), .zero_flag(zero_flag),
  .arch_regs(arch_regs), .cycle_count(cycle_count)
);

// File: tb/mc16_core_bench.sv
module mc16_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid, req_ready, req_we, rsp_valid, halted, zf;
  logic [15:0] req_addr, req_wdata, rsp_rdata, pc;
  logic [1:0] reason;
  logic [63:0] regs;
  logic [CNT_W-1:0] cnt;

  logic [15:0] mem [256];
  logic [15:0] last_wa, last_wd;
  int          wr_cnt;
  logic [7:0]  lfsr = 8'h5A;
  bit          stall_en = 1'b0, junk_rsp = 1'b0, quiet_bad = 1'b0;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc16_core #(.CNT_W(CNT_W)) u_mc16_core (
    .clk(clk), .rst(rst), .mem_req_valid(req_valid), .mem_req_ready(req_ready),
    .mem_req_we(req_we), .mem_req_addr(req_addr), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_rdata(rsp_rdata), .halted(halted),
    .halt_reason(reason), .pc(pc), .zero_flag(zf), .arch_regs(regs), .cycle_count(cnt)
  );

  assign req_ready = stall_en ? lfsr[0] : 1'b1;

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_valid <= junk_rsp;
    if (halted && req_valid) quiet_bad <= 1'b1;
    if (!rst && req_valid && req_ready) begin
      if (req_we) begin
        mem[req_addr[7:0]] <= req_wdata;
        last_wa <= req_addr;
        last_wd <= req_wdata;
        wr_cnt  <= wr_cnt + 1;
      end else begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem[req_addr[7:0]];
      end
    end
  end

  function automatic logic [15:0] rv(int i);
    return regs[i*16 +: 16];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    wr_cnt = 0; last_wa = '0; last_wd = '0; quiet_bad = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(string tag);
    int k;
    do_reset();
    k = 0;
    while (!halted && k < 2000) begin @(negedge clk); k++; end
    check({tag, " R8 halt reached"}, {31'd0, halted}, 32'd1);
  endtask

  initial begin
    logic [3:0]  ops  [4] = '{4'h2, 4'h4, 4'h5, 4'h6};
    logic [7:0]  vals [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd128, 8'd200, 8'd255};
    logic [3:0]  ill  [8] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE};
    logic [15:0] snap_pc, exp_r;
    logic [63:0] snap_regs;
    logic [CNT_W-1:0] snap_cnt;

    // R1 reset state, sampled while reset is still held
    clear_mem();
    repeat (3) @(negedge clk);
    check("R1 regs", regs[31:0], 32'd0);
    check("R1 regs hi", regs[63:32], 32'd0);
    check("R1 pc", {16'd0, pc}, 32'd0);
    check("R1 zf/reason/halt", {28'd0, zf, reason, halted}, 32'd0);
    check("R1 count", cnt, 32'd0);
    check("R2 fetch from 0", {15'd0, req_valid, req_addr}, {15'd0, 1'b1, 16'h0000});

    // R3 R4 R6 R8: load, load, add, store to MEM[R2], halt
    clear_mem();
    mem[0] = 16'h100A; mem[1] = 16'h1105; mem[2] = 16'h2001;
    mem[3] = 16'h3002; mem[4] = 16'hF000;
    run_to_halt("example");
    check("R3 R1=5", {16'd0, rv(1)}, 32'd5);
    check("R4 R0=15", {16'd0, rv(0)}, 32'd15);
    check("R6 store addr", {16'd0, last_wa}, 32'd0);
    check("R6 store data", {16'd0, last_wd}, 32'd15);
    check("R8 pc on halt", {16'd0, pc}, 32'd4);
    check("R8 reason", {30'd0, reason}, 32'd1);

    // R11: frozen after halt despite stray response strobes
    snap_pc = pc; snap_regs = regs; snap_cnt = cnt;
    junk_rsp = 1'b1; stall_en = 1'b1;
    repeat (40) @(negedge clk);
    junk_rsp = 1'b0;
    @(negedge clk);
    check("R11 pc frozen", {16'd0, pc}, {16'd0, snap_pc});
    check("R11 regs frozen", regs[31:0], snap_regs[31:0]);
    check("R11 regs hi frozen", regs[63:32], snap_regs[63:32]);
    check("R12 count frozen", cnt, snap_cnt);
    check("R11 no request", {31'd0, quiet_bad}, 32'd0);
    check("R11 reason held", {30'd0, reason}, 32'd1);

    // R4 R5 R9 R12: sweep of four ops over an operand grid, memory stalling
    stall_en = 1'b1;
    for (int oi = 0; oi < 4; oi++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++) begin
          logic [15:0] a16, b16;
          a16 = {8'd0, vals[ai]}; b16 = {8'd0, vals[bi]};
          case (ops[oi])
            4'h2: exp_r = a16 + b16;
            4'h4: exp_r = a16 - b16;
            4'h5: exp_r = a16 * b16;
            default: exp_r = (b16 == 0) ? a16 : a16 / b16;
          endcase
          clear_mem();
          mem[0] = {8'h10, vals[ai]}; mem[1] = {8'h11, vals[bi]};
          mem[2] = {ops[oi], 12'h001}; mem[3] = 16'hF000;
          run_to_halt("sweep");
          if (ops[oi] == 4'h6 && b16 == 0) begin
            check("R9 reason", {30'd0, reason}, 32'd2);
            check("R9 pc kept", {16'd0, pc}, 32'd2);
            check("R9 R0 kept", {16'd0, rv(0)}, {16'd0, a16});
            check("R9 zf kept", {31'd0, zf}, 32'd0);
          end else begin
            check("R4 result", {16'd0, rv(0)}, {16'd0, exp_r});
            check("R5 zero flag", {31'd0, zf}, {31'd0, exp_r == 16'd0});
            check("R7 pc", {16'd0, pc}, 32'd3);
            check("R8 reason", {30'd0, reason}, 32'd1);
          end
        end

    // R4 truncation: 255*255 squared again
    clear_mem();
    mem[0] = 16'h10FF; mem[1] = 16'h5000; mem[2] = 16'h5000; mem[3] = 16'hF000;
    run_to_halt("mul");
    check("R4 mul truncated", {16'd0, rv(0)}, 32'h0000FC01);

    // R6 R4: store to the top address via SUB wrap
    clear_mem();
    mem[0] = 16'h10AB; mem[1] = 16'h1200; mem[2] = 16'h1301;
    mem[3] = 16'h4203; mem[4] = 16'h3002; mem[5] = 16'hF000;
    run_to_halt("store hi");
    check("R4 sub wrap", {16'd0, rv(2)}, 32'h0000FFFF);
    check("R6 addr FFFF", {16'd0, last_wa}, 32'h0000FFFF);
    check("R6 data", {16'd0, last_wd}, 32'h000000AB);
    check("R5 zf after wrap", {31'd0, zf}, 32'd0);

    // R9: divide by zero keeps a set flag and writes nothing
    clear_mem();
    mem[0] = 16'h1005; mem[1] = 16'h1105; mem[2] = 16'h4001; mem[3] = 16'h6102;
    run_to_halt("divz");
    check("R9 reason", {30'd0, reason}, 32'd2);
    check("R9 pc", {16'd0, pc}, 32'd3);
    check("R9 R1 kept", {16'd0, rv(1)}, 32'd5);
    check("R9 zf kept", {31'd0, zf}, 32'd1);
    check("R9 no write", wr_cnt, 32'd0);

    // R10: every illegal opcode
    for (int ii = 0; ii < 8; ii++) begin
      clear_mem();
      mem[0] = 16'h1307; mem[1] = {ill[ii], 12'h123};
      run_to_halt("illegal");
      check("R10 reason", {30'd0, reason}, 32'd3);
      check("R10 pc", {16'd0, pc}, 32'd1);
      check("R10 R3 kept", {16'd0, rv(3)}, 32'd7);
      check("R10 R1 untouched", {16'd0, rv(1)}, 32'd0);
      check("R10 no write", wr_cnt, 32'd0);
    end

    // R7: forward jump skips a word
    clear_mem();
    mem[0] = 16'h1001; mem[1] = 16'h7003; mem[2] = 16'h1009;
    mem[3] = 16'h2000; mem[4] = 16'hF000;
    run_to_halt("jmp");
    check("R7 skipped load", {16'd0, rv(0)}, 32'd2);
    check("R7 pc", {16'd0, pc}, 32'd4);

    // R7 R12: backward-jump loop runs on; counter steps every cycle
    stall_en = 1'b0;
    clear_mem();
    mem[0] = 16'h1101; mem[1] = 16'h2001; mem[2] = 16'h7001;
    do_reset();
    repeat (300) @(negedge clk);
    check("R12 count per cycle", cnt, 32'd300);
    check("R7 loop not halted", {29'd0, halted, reason}, 32'd0);
    check("R7 loop progressed", {31'd0, rv(0) > 16'd10}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule